// File: doc/BRIEF.md
# Whole-Array Erase Verify Controller

This controller sequences the erasure of a small byte-wide non-volatile array. Once a start command is accepted it drives a whole-array erase pulse of a programmable number of clock cycles. It then reads the array one byte at a time through a simple read port. Each byte must come back as all ones. There is no pre-programming step: the first action after start is the erase pulse itself.

When a byte is not blank, the controller erases the whole array again. Single bytes are never erased on their own. The failing address is kept, and the next verify pass starts there instead of at zero. The number of erase pulses has an upper limit. If a byte still fails after the last allowed pulse, the sequence ends with a fail flag. A 4-bit counter shows how many pulses the current run has used.

A host starts the run with a one-cycle strobe and watches `busy_o`. It then reads the outcome from `done_o` and `fail_o`, which keep their values until the next start.

Top module: `erase_verify_ctrl`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, erase_pulse_o and rd_en_o are 0, and pulse_cnt_o is 0.
- R2: A start_i seen while idle is accepted. From the next cycle busy_o is 1 and the erase pulse is active. No read strobe is issued before the first erase pulse.
- R3: Every erase pulse keeps erase_pulse_o high for exactly PULSE_CYCLES consecutive cycles.
- R4: The first verify pass starts at address 0 and steps upward by one per byte. Each read keeps rd_en_o high for a single cycle, with the byte address on rd_addr_o.
- R5: rd_data_i is sampled exactly RD_LAT clock edges after the edge that captured the read strobe. A byte passes only when it equals 0xFF.
- R6: A failing byte starts a new whole-array erase pulse. pulse_cnt_o increments by one for every pulse issued.
- R7: After a re-erase, verification resumes at the address of the byte that failed, not at address 0. Addresses below it are not read again.
- R8: When the byte at the top address (all address bits one) passes, the run ends with done_o=1, fail_o=0 and busy_o=0.
- R9: At most MAX_PULSES erase pulses are issued. A failing byte after the last allowed pulse ends the run with done_o=1, fail_o=1 and busy_o=0.
- R10: Accepting a start clears the pulse count. The first pulse of the run is counted at once, so pulse_cnt_o reads 1 in the cycle after the start is accepted.
- R11: start_i is ignored while busy_o is 1. It restarts neither the pulse nor the count nor the scan.
- R12: done_o and fail_o hold their values while idle and clear in the cycle after the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (sticky until next start) |
| fail_o | output | 1 | Run finished without a blank array (sticky) |
| erase_pulse_o | output | 1 | Whole-array erase request |
| rd_en_o | output | 1 | Byte read strobe, one cycle per byte |
| rd_addr_o | output | ADDR_W | Byte address for the read |
| rd_data_i | input | 8 | Read data, valid RD_LAT edges after the strobe |
| pulse_cnt_o | output | CNT_W | Erase pulses used in the current run |

## Verification
The bench builds the controller with a 4-bit address (16 bytes), 6-cycle erase pulses, RD_LAT of 2 and the default limit of 10 pulses. With these values every pulse and read window is short. A run that needs all ten pulses fits well within the cycle budget, so both the exact-tenth-pulse pass and the over-limit failure can be reached. The array model marks each byte with the number of pulses it needs before it turns blank. Its read data is valid for only one cycle, so sampling one cycle early or late shows up as a wrong verify result. The 16-entry array is small enough that a byte failing at the top address can be placed directly.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ERASE = 2'd1,
    ST_VREQ  = 2'd2,
    ST_VWAIT = 2'd3
  } evc_state_t;

  // A byte counts as erased only when every bit reads one.
  function automatic logic byte_is_blank(input logic [7:0] b);
    return &b;
  endfunction

  // Counter width that holds values 0..n-1 (at least one bit).
  function automatic int unsigned span_width(input longint unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/evc_pulse_gen.sv
module evc_pulse_gen #(
  parameter int unsigned PULSE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic active_o,
  output logic last_o
);
  import evc_pkg::*;

  localparam int unsigned TW = span_width(PULSE_CYCLES);

  logic          active_q;
  logic [TW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (fire_i) begin
      active_q <= 1'b1;
      left_q   <= TW'(PULSE_CYCLES - 1);
    end else if (active_q) begin
      if (left_q == '0) active_q <= 1'b0;
      else              left_q   <= left_q - 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q && (left_q == '0);

  AST_FIRE_WHEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |-> !active_q); // R3

  AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !fire_i) |=> !active_o); // R3

endmodule

// File: rtl/evc_read_port.sv
module evc_read_port #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              sample_o,
  output logic              blank_o
);
  import evc_pkg::*;

  localparam int unsigned LW = span_width(RD_LAT);

  logic              issue_q;
  logic              wait_q;
  logic [LW-1:0]     wcnt_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
      wait_q  <= 1'b0;
      wcnt_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (go_i) begin
        issue_q <= 1'b1;
        addr_q  <= addr_i;
      end else if (issue_q) begin
        issue_q <= 1'b0;
        wait_q  <= 1'b1;
        wcnt_q  <= LW'(RD_LAT - 1);
      end else if (wait_q) begin
        if (wcnt_q == '0) wait_q <= 1'b0;
        else              wcnt_q <= wcnt_q - 1'b1;
      end
    end
  end

  assign rd_en_o   = issue_q;
  assign rd_addr_o = addr_q;
  assign sample_o  = wait_q && (wcnt_q == '0);
  assign blank_o   = byte_is_blank(rd_data_i);

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |=> !rd_en_o); // R4

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (!issue_q && !wait_q)); // R5

endmodule

// File: rtl/evc_pulse_tally.sv
module evc_pulse_tally #(
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned MAX_PULSES = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             spent_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign spent_o = (cnt_q >= CNT_W'(MAX_PULSES));

  AST_TALLY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= CNT_W'(MAX_PULSES)); // R9

  AST_NO_INC_SPENT: assert property (@(posedge clk) disable iff (!rst_n)
    (spent_o && !clear_i) |-> !inc_i); // R9

endmodule

// File: rtl/erase_verify_ctrl.sv
module erase_verify_ctrl #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PULSE_CYCLES = 50_000_000,
  parameter int unsigned MAX_PULSES   = 10,
  parameter int unsigned RD_LAT       = 2,
  parameter int unsigned CNT_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              erase_pulse_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic [CNT_W-1:0]  pulse_cnt_o
);
  import evc_pkg::*;

  evc_state_t        state_q;
  logic [ADDR_W-1:0] scan_addr_q;
  logic              done_q;
  logic              fail_q;

  // Named internal events
  logic accept_w, pulse_last_w, sample_w, blank_w, spent_w;
  logic pass_byte_w, fail_byte_w, at_top_w;
  logic finish_pass_w, finish_fail_w, reerase_w, fire_w, go_w;

  assign accept_w      = (state_q == ST_IDLE) && start_i;
  assign at_top_w      = &scan_addr_q;
  assign pass_byte_w   = (state_q == ST_VWAIT) && sample_w && blank_w;
  assign fail_byte_w   = (state_q == ST_VWAIT) && sample_w && !blank_w;
  assign finish_pass_w = pass_byte_w && at_top_w;
  assign finish_fail_w = fail_byte_w && spent_w;
  assign reerase_w     = fail_byte_w && !spent_w;
  assign fire_w        = accept_w || reerase_w;
  assign go_w          = (state_q == ST_VREQ);

  evc_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (fire_w),
    .active_o (erase_pulse_o),
    .last_o   (pulse_last_w)
  );

  evc_read_port #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_i      (go_w),
    .addr_i    (scan_addr_q),
    .rd_en_o   (rd_en_o),
    .rd_addr_o (rd_addr_o),
    .rd_data_i (rd_data_i),
    .sample_o  (sample_w),
    .blank_o   (blank_w)
  );

  evc_pulse_tally #(.CNT_W(CNT_W), .MAX_PULSES(MAX_PULSES)) u_tally (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (accept_w),
    .inc_i   (fire_w),
    .count_o (pulse_cnt_o),
    .spent_o (spent_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      scan_addr_q <= '0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          state_q     <= ST_ERASE;
          scan_addr_q <= '0;
          done_q      <= 1'b0;
          fail_q      <= 1'b0;
        end
        ST_ERASE: if (pulse_last_w) state_q <= ST_VREQ;
        ST_VREQ:  state_q <= ST_VWAIT;
        ST_VWAIT: if (sample_w) begin
          if (finish_pass_w) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else if (pass_byte_w) begin
            scan_addr_q <= scan_addr_q + 1'b1;
            state_q     <= ST_VREQ;
          end else if (finish_fail_w) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            fail_q  <= 1'b1;
          end else begin
            // failing address is kept in scan_addr_q for the resumed pass
            state_q <= ST_ERASE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign fail_o = fail_q;

  AST_PULSE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    erase_pulse_o |-> !rd_en_o); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy_o && erase_pulse_o)); // R2

  AST_ACCEPT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (pulse_cnt_o == CNT_W'(1))); // R10

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R8

  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail_o |-> done_o); // R9

  AST_RESUME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    reerase_w |=> $stable(scan_addr_q)); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !finish_pass_w && !finish_fail_w) |=> busy_o); // R11

endmodule

// File: tb/erase_verify_ctrl_tb_top.sv
module erase_verify_ctrl_tb_top;
  localparam int AW  = 4;
  localparam int NB  = 16;
  localparam int PC  = 6;
  localparam int MP  = 10;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, fail, pulse, rd_en;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data;
  logic [3:0]    pcnt;

  always #5 clk = ~clk;

  erase_verify_ctrl #(
    .ADDR_W(AW), .PULSE_CYCLES(PC), .MAX_PULSES(MP), .RD_LAT(LAT), .CNT_W(4)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .fail_o(fail), .erase_pulse_o(pulse), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .pulse_cnt_o(pcnt)
  );

  // ---------------- array model ----------------
  int         need [NB];
  logic [7:0] mem  [NB];
  int         pulses_seen, pulse_len, bad_len, early_reads, log_n;
  int         log_a [64];
  logic       pulse_q;
  logic [7:0] pipe_d [LAT];
  logic       pipe_v [LAT];

  assign rd_data = pipe_v[LAT-1] ? pipe_d[LAT-1] : 8'h00;

  always @(posedge clk) begin
    pulse_q <= pulse;
    if (pulse && !pulse_q) begin
      pulses_seen++;
      for (int i = 0; i < NB; i++)
        mem[i] = (need[i] <= pulses_seen) ? 8'hFF : {4'b1110, 4'(i)};
    end
    if (pulse) pulse_len++;
    else if (pulse_q) begin
      if (pulse_len != PC) bad_len++;
      pulse_len = 0;
    end
    if (rd_en) begin
      if (pulses_seen == 0) early_reads++;
      if (log_n < 64) log_a[log_n] = int'(rd_addr);
      log_n++;
    end
    pipe_v[0] <= rd_en;
    pipe_d[0] <= mem[rd_addr];
    for (int k = 1; k < LAT; k++) begin
      pipe_v[k] <= pipe_v[k-1];
      pipe_d[k] <= pipe_d[k-1];
    end
  end

  // ---------------- bookkeeping ----------------
  int total = 0;
  int bad = 0;
  int exp_seq [64];
  int exp_n, exp_p, exp_fail;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NB; i++) begin
      mem[i]  = 8'h00;
      need[i] = 1;
    end
    pulses_seen = 0; pulse_len = 0; bad_len = 0; early_reads = 0; log_n = 0;
  endtask

  // Expected read order, pulse count and outcome from the requirements.
  task automatic compute_expect();
    int p = 1;
    int a = 0;
    exp_n = 0; exp_fail = 0;
    while (1) begin
      if (exp_n < 64) exp_seq[exp_n] = a;
      exp_n++;
      if (need[a] <= p) begin
        if (a == NB - 1) break;
        a++;
      end else begin
        if (p == MP) begin exp_fail = 1; break; end
        p++;
      end
    end
    exp_p = p;
  endtask

  task automatic run_and_check(input string tag, input bit mid_start);
    int guard = 0;
    int mism = 0;
    compute_expect();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1 && pulse == 1'b1, {tag, " R2 busy+pulse after start"}, int'(busy), 1);
    check(pcnt == 4'd1, {tag, " R10 count after start"}, int'(pcnt), 1);
    check(done == 1'b0 && fail == 1'b0, {tag, " R12 flags cleared"}, int'(done), 0);
    if (mid_start) begin
      repeat (9) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!done && guard < 5000) begin
      @(negedge clk); guard++;
    end
    check(done == 1'b1 && busy == 1'b0, {tag, " R8 done and idle"}, int'(done), 1);
    check(int'(fail) == exp_fail, {tag, " R8/R9 fail flag"}, int'(fail), exp_fail);
    check(int'(pcnt) == exp_p, {tag, " R6 pulse count"}, int'(pcnt), exp_p);
    check(pulses_seen == exp_p, {tag, " R6 pulses issued"}, pulses_seen, exp_p);
    check(bad_len == 0, {tag, " R3 pulse length"}, bad_len, 0);
    check(early_reads == 0, {tag, " R2 no read before erase"}, early_reads, 0);
    check(log_n == exp_n, {tag, " R4/R7 read count"}, log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n && i < 64; i++)
      if (log_a[i] != exp_seq[i]) mism++;
    check(mism == 0, {tag, " R4/R7 read address order"}, mism, 0);
    repeat (4) @(negedge clk);
    check(done == 1'b1 && int'(fail) == exp_fail, {tag, " R12 flags held"}, int'(done), 1);
  endtask

  task automatic t_reset();
    check(!busy && !done && !fail && !pulse && !rd_en, "R1 outputs idle", int'(busy), 0);
    check(pcnt == 4'd0, "R1 count zero", int'(pcnt), 0);
  endtask

  task automatic t_clean();
    model_reset();
    run_and_check("clean R4 R5", 1'b0);
  endtask

  task automatic t_resume();
    model_reset();
    need[5] = 2; need[9] = 3;
    run_and_check("resume R6 R7", 1'b0);
  endtask

  task automatic t_top();
    model_reset();
    need[NB-1] = 2;
    run_and_check("top R7 R8", 1'b0);
  endtask

  task automatic t_tenth();
    model_reset();
    need[3] = MP;
    run_and_check("tenth R9", 1'b0);
  endtask

  task automatic t_cap();
    model_reset();
    need[2] = MP + 1;
    run_and_check("cap R9", 1'b0);
  endtask

  task automatic t_busy_start();
    model_reset();
    need[4] = 3;
    run_and_check("busy start R11", 1'b1);
  endtask

  initial begin
    model_reset();
    pulse_q = 1'b0;
    for (int k = 0; k < LAT; k++) begin pipe_v[k] = 1'b0; pipe_d[k] = 8'h00; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_clean();
    t_resume();
    t_top();
    t_tenth();
    t_cap();
    t_busy_start();
    t_clean();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule